// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register front end of a 16-pin general-purpose I/O port. A simple register bus reaches it with a byte offset, an access size, read and write strobes and a write word. The block holds five pieces of per-port state: a function-enable mask, the output data word, the pin direction word, an input-enable mask and a 32-bit pin-mux word. The mux word is only stored here. Routing the pins through it is done elsewhere.

The data word and the direction word have set and clear alias registers. Writing a 1 to an alias bit sets or clears the matching bit, so software can change single pins without a read-modify-write. The direction word has no plain write path at all. Each register accepts exactly one access size. A size fault is reported ahead of an unmapped-offset fault, and neither fault changes any state.

The pins have gated paths in both directions. After each write that can move output levels, the pins that have input disabled present their data bit on a registered output. An input level reaches a registered per-pin input value only when that pin is an input, has input enabled and has its function enabled. In every other case the level is ignored.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every register reads as zero, `pin_out` is all zeros and `in_val` is all zeros.
- R2: `bus_size` 0 means a 2-byte access and 1 means a 4-byte access. Offset 0x1C (mux) needs size 1. Every other offset needs size 0. A mismatch on an active access gives `bus_err` = 2'b01.
- R3: An access of the correct size whose offset is not a multiple of 4, or is above 0x1C, gives `bus_err` = 2'b10. When both faults apply, the size fault (2'b01) is the one reported. A clean access gives 2'b00.
- R4: A faulted write changes no register and no pin output. A faulted read returns zero on `bus_rdata`.
- R5: These registers are written directly from the bus:
  - function enable at 0x00, from `bus_wdata[15:0]`;
  - data at 0x04, from `bus_wdata[15:0]`;
  - input enable at 0x18, from `bus_wdata[15:0]`;
  - mux at 0x1C, from the full 32-bit word.
  Each of them reads back its stored value, with bits 31:16 zero for the 16-bit registers.
- R6: A write to 0x08 ORs `bus_wdata[15:0]` into data. A write to 0x0C clears every data bit where the written value is 1. Reading 0x08 or 0x0C returns the current data word.
- R7: Direction changes only through its aliases. A write to 0x10 ORs the value into direction and a write to 0x14 clears the bits written as 1. Reading 0x10 or 0x14 returns the direction word.
- R8: A clean write to 0x04, 0x08, 0x0C or 0x10 updates `pin_out` on the same clock edge. Each pin whose input-enable bit is 0 takes its new data bit, and the other pins hold. No other write, including one to 0x14, changes `pin_out`.
- R9: On each clock edge, `in_val[i]` takes `pin_in[i]` when direction bit i is 0, input-enable bit i is 1 and function-enable bit i is 1. Otherwise it holds its value.
- R10: `bus_rdata` and `bus_err` are combinational in the cycle of the strobe, and a write takes effect on the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 1 | 0 = 2-byte access, 1 = 4-byte access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, zero when faulted or idle |
| bus_err | output | 2 | 00 ok, 01 size fault, 10 address fault |
| pin_in | input | 16 | Levels seen on the pins |
| pin_out | output | 16 | Registered output levels |
| in_val | output | 16 | Registered accepted input levels |

## Verification
The bench targets fault priority with an unmapped offset at the wrong size, so a design that checks the offset first would report 2'b10 there instead of 2'b01. It also issues faulted writes and then reads the registers back, which exposes any design that commits the write anyway. A write to direction-clear followed by direction-set catches a design that refreshes the pins on the wrong writes, because `pin_out` would then move one write early. Input gating is driven through every mix of the three control bits, so dropping any one term of the gate shows up as `in_val` following a pin it should ignore.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned NUM_REGS = 8;

  // Register slot = byte offset / 4; the order sets the address map.
  typedef enum logic [2:0] {
    SLOT_FUNC = 3'd0,
    SLOT_DATA = 3'd1,
    SLOT_DSET = 3'd2,
    SLOT_DCLR = 3'd3,
    SLOT_DIRS = 3'd4,
    SLOT_DIRC = 3'd5,
    SLOT_INEN = 3'd6,
    SLOT_MUX  = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    FAULT_NONE = 2'b00,
    FAULT_SIZE = 2'b01,
    FAULT_ADDR = 2'b10
  } fault_e;

  function automatic logic [31:0] or_in(logic [31:0] cur, logic [31:0] val);
    return cur | val;
  endfunction

  function automatic logic [31:0] knock_out(logic [31:0] cur, logic [31:0] val);
    return cur & ~val;
  endfunction

  function automatic logic [31:0] input_gate(logic [31:0] dir, logic [31:0] ien,
                                             logic [31:0] fen);
    return ~dir & ien & fen;
  endfunction

  function automatic logic [31:0] pick_bits(logic [31:0] sel, logic [31:0] a,
                                            logic [31:0] b);
    return (sel & a) | (~sel & b);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              size4,
  input  logic              active,
  output fault_e            fault,
  output logic              hit,
  output slot_e             slot
);
  localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'((NUM_REGS - 1) * 4);

  logic is_mux, aligned, in_range;

  assign is_mux   = (addr == LAST_OFF);
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (addr <= LAST_OFF);
  assign slot     = slot_e'(addr[4:2]);

  always_comb begin
    fault = FAULT_NONE;
    if (active) begin
      if (size4 != is_mux)           fault = FAULT_SIZE;
      else if (!aligned || !in_range) fault = FAULT_ADDR;
    end
  end

  assign hit = active && (fault == FAULT_NONE);
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned MUX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  slot_e            slot,
  input  logic [31:0]      wdata,
  output logic [NPINS-1:0] fen_q,
  output logic [NPINS-1:0] data_q,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] ien_q,
  output logic [MUX_W-1:0] mux_q,
  output logic [NPINS-1:0] data_nxt,
  output logic [NUM_REGS-1:0] wr_fire,
  output logic             out_refresh,
  output logic [31:0]      rd_word
);
  logic [NPINS-1:0] wval, dir_nxt;

  assign wval = wdata[NPINS-1:0];

  for (genvar s = 0; s < NUM_REGS; s++) begin : g_fire
    assign wr_fire[s] = wr_en && (slot == slot_e'(s));
  end

  assign out_refresh = wr_fire[SLOT_DATA] | wr_fire[SLOT_DSET] |
                       wr_fire[SLOT_DCLR] | wr_fire[SLOT_DIRS];

  always_comb begin
    data_nxt = data_q;
    dir_nxt  = dir_q;
    if (wr_fire[SLOT_DATA]) data_nxt = wval;
    if (wr_fire[SLOT_DSET]) data_nxt = NPINS'(or_in(32'(data_q), 32'(wval)));
    if (wr_fire[SLOT_DCLR]) data_nxt = NPINS'(knock_out(32'(data_q), 32'(wval)));
    if (wr_fire[SLOT_DIRS]) dir_nxt  = NPINS'(or_in(32'(dir_q), 32'(wval)));
    if (wr_fire[SLOT_DIRC]) dir_nxt  = NPINS'(knock_out(32'(dir_q), 32'(wval)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fen_q  <= '0;
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      mux_q  <= '0;
    end else begin
      data_q <= data_nxt;
      dir_q  <= dir_nxt;
      if (wr_fire[SLOT_FUNC]) fen_q <= wval;
      if (wr_fire[SLOT_INEN]) ien_q <= wval;
      if (wr_fire[SLOT_MUX])  mux_q <= wdata[MUX_W-1:0];
    end
  end

  always_comb begin
    unique case (slot)
      SLOT_FUNC:                       rd_word = 32'(fen_q);
      SLOT_DATA, SLOT_DSET, SLOT_DCLR: rd_word = 32'(data_q);
      SLOT_DIRS, SLOT_DIRC:            rd_word = 32'(dir_q);
      SLOT_INEN:                       rd_word = 32'(ien_q);
      default:                         rd_word = 32'(mux_q);
    endcase
  end
endmodule

// File: rtl/gpio_pin_gate.sv
module gpio_pin_gate
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_refresh,
  input  logic [NPINS-1:0] data_nxt,
  input  logic [NPINS-1:0] fen_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] ien_q,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] in_gate,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] in_val
);
  assign in_gate = NPINS'(input_gate(32'(dir_q), 32'(ien_q), 32'(fen_q)));

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pin_out[p] <= 1'b0;
        in_val[p]  <= 1'b0;
      end else begin
        if (out_refresh && !ien_q[p]) pin_out[p] <= data_nxt[p];
        if (in_gate[p])               in_val[p]  <= pin_in[p];
      end
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned MUX_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        bus_err,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  in_val
);
  fault_e             fault;
  logic               hit;
  slot_e              slot;
  logic [NPINS-1:0]   fen_q, data_q, dir_q, ien_q, data_nxt, in_gate;
  logic [MUX_W-1:0]   mux_q;
  logic [NUM_REGS-1:0] wr_fire;
  logic               out_refresh;
  logic [31:0]        rd_word;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .size4  (bus_size),
    .active (bus_wr | bus_rd),
    .fault  (fault),
    .hit    (hit),
    .slot   (slot)
  );

  gpio_reg_bank #(.NPINS(NPINS), .MUX_W(MUX_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_wr & hit),
    .slot        (slot),
    .wdata       (bus_wdata),
    .fen_q       (fen_q),
    .data_q      (data_q),
    .dir_q       (dir_q),
    .ien_q       (ien_q),
    .mux_q       (mux_q),
    .data_nxt    (data_nxt),
    .wr_fire     (wr_fire),
    .out_refresh (out_refresh),
    .rd_word     (rd_word)
  );

  gpio_pin_gate #(.NPINS(NPINS)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_refresh (out_refresh),
    .data_nxt    (data_nxt),
    .fen_q       (fen_q),
    .dir_q       (dir_q),
    .ien_q       (ien_q),
    .pin_in      (pin_in),
    .in_gate     (in_gate),
    .pin_out     (pin_out),
    .in_val      (in_val)
  );

  assign bus_err   = fault;
  assign bus_rdata = (bus_rd && hit) ? rd_word : 32'd0;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned MUX_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_size,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [1:0]        bus_err,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  in_val,
  input logic [NPINS-1:0]  fen_q,
  input logic [NPINS-1:0]  data_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  ien_q,
  input logic [MUX_W-1:0]  mux_q,
  input logic [NPINS-1:0]  in_gate,
  input logic [7:0]        wr_fire,
  input logic              out_refresh
);
  localparam logic [ADDR_W-1:0] MUX_OFF = ADDR_W'(28);

  assert_size_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && ((bus_addr == MUX_OFF) != bus_size) |-> bus_err == 2'b01);

  assert_addr_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && !bus_size && (bus_addr[1:0] != 2'b00) |-> bus_err == 2'b10);

  assert_fault_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_err != 2'b00) |=> $stable(data_q) && $stable(dir_q) &&
      $stable(fen_q) && $stable(ien_q) && $stable(mux_q) && $stable(pin_out));

  assert_fault_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_err != 2'b00) |-> bus_rdata == 32'd0);

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_fire));

  assert_data_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire[2] |=> data_q == ($past(data_q) | $past(bus_wdata[NPINS-1:0])));

  assert_data_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire[3] |=> data_q == ($past(data_q) & ~$past(bus_wdata[NPINS-1:0])));

  assert_dir_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire[4] |=> dir_q == ($past(dir_q) | $past(bus_wdata[NPINS-1:0])));

  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire[4] && !wr_fire[5] |=> $stable(dir_q));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_refresh |=> $stable(pin_out));

  assert_in_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((in_val ^ $past(in_val)) & ~$past(in_gate)) == '0);

  assert_in_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((in_val ^ $past(pin_in)) & $past(in_gate)) == '0);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .MUX_W(MUX_W)) u_chk (.*);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_size = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_err;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] in_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [NP-1:0] m_fen, m_data, m_dir, m_ien, m_out, m_in;
  logic [31:0]   m_mux;

  gpio_port_regs u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_err(logic [7:0] a, logic four);
    bit want_four = (a == 8'd28);
    if (four != want_four) return 2'b01;           // size first
    if ((a % 4) != 0 || a > 8'd28) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a, logic four);
    if (exp_err(a, four) != 2'b00) return 32'd0;
    case (a / 4)
      0: return {16'd0, m_fen};
      1, 2, 3: return {16'd0, m_data};
      4, 5: return {16'd0, m_dir};
      6: return {16'd0, m_ien};
      default: return m_mux;
    endcase
  endfunction

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_fen = 0; m_data = 0; m_dir = 0; m_ien = 0; m_out = 0; m_in = 0; m_mux = 0;
    end else begin
      for (int i = 0; i < NP; i++)
        if (m_dir[i] == 1'b0 && m_ien[i] && m_fen[i]) m_in[i] = pin_in[i];
      if (bus_wr && exp_err(bus_addr, bus_size) == 2'b00) begin
        case (bus_addr / 4)
          0: m_fen = bus_wdata[15:0];
          1: m_data = bus_wdata[15:0];
          2: m_data = m_data | bus_wdata[15:0];
          3: m_data = m_data & ~bus_wdata[15:0];
          4: m_dir = m_dir | bus_wdata[15:0];
          5: m_dir = m_dir & ~bus_wdata[15:0];
          6: m_ien = bus_wdata[15:0];
          default: m_mux = bus_wdata;
        endcase
        if (bus_addr >= 8'd4 && bus_addr <= 8'd16)
          for (int i = 0; i < NP; i++)
            if (!m_ien[i]) m_out[i] = m_data[i];
      end
    end
  end

  // every-cycle compare of pin-side outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pin_out === m_out, "R8 pin_out", 32'(pin_out), 32'(m_out));
      chk(in_val === m_in, "R9 in_val", 32'(in_val), 32'(m_in));
    end
  end

  task automatic access(input logic wr, input logic [7:0] a, input logic four,
                        input logic [31:0] d, input string req);
    @(negedge clk);
    bus_addr = a; bus_size = four; bus_wr = wr; bus_rd = !wr; bus_wdata = d;
    #1;
    chk(bus_err === exp_err(a, four), {req, " err"}, 32'(bus_err), 32'(exp_err(a, four)));
    if (!wr) chk(bus_rdata === exp_read(a, four), {req, " rdata"}, bus_rdata, exp_read(a, four));
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic read_all(input string req);
    for (int s = 0; s < 8; s++) access(1'b0, 8'(s * 4), s == 7, 32'd0, req);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk); pin_in = v;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    chk(pin_out === '0, "R1 pin_out", 32'(pin_out), 0);
    chk(in_val === '0, "R1 in_val", 32'(in_val), 0);
    read_all("R1 reset read");

    // R5 direct writes, R10 same-cycle response
    access(1, 8'h00, 0, 32'hABCD_5A5A, "R5 fen write");
    access(1, 8'h18, 0, 32'h1234_00F0, "R5 ien write");
    access(1, 8'h1C, 1, 32'hDEAD_BEEF, "R5 mux write");
    read_all("R5 readback");

    // R8 data write drives only input-disabled pins
    access(1, 8'h04, 0, 32'h0000_FFFF, "R8 data write");
    access(1, 8'h08, 0, 32'h0000_0000, "R6 set zero");
    access(1, 8'h0C, 0, 32'h0000_0F0F, "R6 clear");
    access(1, 8'h08, 0, 32'h0000_0101, "R6 set");
    access(0, 8'h08, 0, 0, "R6 read set alias");
    access(0, 8'h0C, 0, 0, "R6 read clear alias");

    // R7 direction, R8 refresh rules
    access(1, 8'h18, 0, 32'h0000_FFFF, "R8 ien all");
    access(1, 8'h04, 0, 32'h0000_00FF, "R8 data masked");
    access(1, 8'h18, 0, 32'h0000_0000, "R8 ien none");
    access(1, 8'h14, 0, 32'h0000_0001, "R8 dirclr no refresh");
    chk(pin_out !== 16'h00FF, "R8 dirclr held", 32'(pin_out), 32'h00FF);
    access(1, 8'h10, 0, 32'h0000_8001, "R7 dirset refresh");
    access(1, 8'h14, 0, 32'h0000_0001, "R7 dirclr");
    access(0, 8'h10, 0, 0, "R7 read dirset alias");
    access(0, 8'h14, 0, 0, "R7 read dirclr alias");

    // R2/R3/R4 faults
    access(1, 8'h1C, 0, 32'h1111_1111, "R2 mux short");
    access(1, 8'h04, 1, 32'h0000_0000, "R2 data long");
    access(0, 8'h00, 1, 0, "R2 fen long read");
    access(1, 8'h20, 0, 32'hFFFF_FFFF, "R3 past end");
    access(1, 8'h24, 1, 32'hFFFF_FFFF, "R3 size before addr");
    access(1, 8'h02, 0, 32'hFFFF_FFFF, "R3 unaligned");
    access(0, 8'h1E, 0, 0, "R3 unaligned read");
    access(1, 8'h1D, 1, 32'h0, "R3 unaligned long");
    read_all("R4 no change");

    // R9 input gating over all control combinations
    access(1, 8'h18, 0, 32'h0000_F0F0, "R9 ien");
    access(1, 8'h00, 0, 32'h0000_CCCC, "R9 fen");
    access(1, 8'h10, 0, 32'h0000_AAAA, "R9 dir");
    set_pins(16'hFFFF);
    set_pins(16'h0000);
    set_pins(16'h5A5A);
    access(1, 8'h14, 0, 32'h0000_FFFF, "R9 dir clear");
    set_pins(16'hFFFF);
    set_pins(16'h3C3C);

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      logic four;
      int pick = $urandom_range(0, 9);
      a = (pick < 8) ? 8'(pick * 4) : 8'($urandom_range(0, 40));
      four = ($urandom_range(0, 9) == 0) ? !(a == 8'd28) : (a == 8'd28);
      pin_in = 16'($urandom);
      access($urandom_range(0, 1) == 1, a, four, $urandom, "R10 random");
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule